// File: doc/BRIEF.md
# Interleaved SPI Converter Channel Sequencer

This block sequences one SPI DAC and one SPI ADC over a frame of N analog channels. N is 2, 4 or 8. For every channel it sends a 32-bit DAC write that carries one 16-bit sample. It then sends a 16-bit ADC configuration word that picks a channel to convert, and it takes the 16-bit result back. DAC samples come in as 32-bit words that each hold two channels. ADC results go out packed two per 32-bit word, one word for each channel pair.

The ADC returns each result two transfers after the command that asked for it. So the channel selected for frame index i is (i+2) masked to N-1. After reset the block runs the converter power-up sequence, which includes two priming conversions for channels 0 and 1. The first result of every frame therefore belongs to channel 0. The serial shifter sits outside the block and is reached through a word-level request/done handshake. The shifter supplies the chip-select timing only through that handshake.

Top module: `spi_chan_seq`

## Requirements
- R1: While reset is asserted, dac_cs_n and adc_cs_n are 1, and xfer_req, smp_req, res_valid and frame_done are 0.
- R2: After reset, with no start, the block makes exactly five transfers in this order: DAC 0x07000000 (power-on reset), ADC 0x0000F120, DAC 0x08000001 (internal reference on), ADC 0x0000F120 (prime channel 0), ADC 0x0000F320 (prime channel 1). After that it stays idle.
- R3: A DAC sample write for channel c is the 32-bit word with 0x3 in bits [27:24], c in bits [23:20], the sample in bits [19:4], and zero in bits [31:28] and [3:0].
- R4: The ADC word sent at frame channel index c is 0xF120 OR (((c+2) mod N) << 9) in bits [15:0], with bits [31:16] zero.
- R5: Within a frame, channels are handled in order 0..N-1, each as a DAC write followed by an ADC transfer. smp_req pulses once per channel pair, in the cycle the even channel's DAC write is issued. The even channel uses smp_word[15:0] and the odd channel uses smp_word[31:16], as captured at that pulse.
- R6: After the second ADC transfer of each pair, res_valid pulses for one cycle. res_word[15:0] holds the first received word of the pair and res_word[31:16] holds the second. Result pair p belongs to channels 2p and 2p+1.
- R7: The chan_req value sampled at start sets N: 8 if chan_req >= 8, 4 if it is 4..7, and 2 otherwise. A frame makes exactly 2N transfers.
- R8: A DAC transfer drives dac_cs_n low, xfer_len 32 and xfer_mode 1. An ADC transfer drives adc_cs_n low, xfer_len 16 and xfer_mode 0. The two chip selects are never low together, and both are high in the cycle after xfer_done.
- R9: xfer_req stays high until xfer_done. A new transfer begins only while both chip selects are high.
- R10: frame_done pulses once, together with the last res_valid of the frame. A start that arrives during power-up or during a frame is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin one frame when idle |
| chan_req | input | REQ_W | Requested channel count |
| smp_req | output | 1 | Sample word taken this cycle |
| smp_word | input | 32 | Two DAC samples, even channel in the low half |
| res_valid | output | 1 | res_word holds a packed result pair |
| res_word | output | 32 | Two ADC results, first in the low half |
| frame_done | output | 1 | Frame completed |
| dac_cs_n | output | 1 | DAC chip select, active low |
| adc_cs_n | output | 1 | ADC chip select, active low |
| xfer_req | output | 1 | Shift request to the serial engine |
| xfer_word | output | 32 | Word to shift out |
| xfer_len | output | 6 | Word length in bits |
| xfer_mode | output | 2 | SPI clock mode |
| xfer_done | input | 1 | Shift complete, received word valid |
| xfer_rx | input | 16 | Low 16 bits of the received word |

## Verification
The assertions watch the properties that hold on every cycle. They check that the chip selects are exclusive and released after done, that a request is held until done, that no command is issued while a chip select is low, that the step index stays in range, and that the channel count stays frozen while the block is busy. Other behaviour shows only through the bench's scenarios, where a model ADC answers each conversion two commands late and tags each answer with its channel. Those scenarios show the exact power-up words, the DAC and ADC word contents for each channel count, the ordering within a pair, the packing of results, and channel alignment across frames of different sizes. They also show that start is ignored mid-frame and during power-up.

// File: rtl/spi_seq_pkg.sv
package spi_seq_pkg;
  localparam int CH_MAX  = 8;
  localparam int CH_W    = $clog2(CH_MAX);
  localparam int STEP_W  = $clog2(2 * CH_MAX);
  localparam int WORD_W  = 32;
  localparam int HALF_W  = 16;
  localparam int INIT_LAST = 4;
  localparam logic [3:0]  DAC_OP_WRITE = 4'h3;
  localparam logic [15:0] ADC_CFG_BASE = 16'hF120;
  localparam int          ADC_CH_LSB   = 9;

  typedef enum logic [1:0] {SQ_INIT, SQ_IDLE, SQ_FRAME} seq_st_t;
  typedef enum logic [1:0] {XP_IDLE, XP_SETUP, XP_SHIFT} xfer_ph_t;

  // channel count rounding: returns log2 of N
  function automatic logic [1:0] norm_lg(input int unsigned req);
    if (req >= 8)      return 2'd3;
    else if (req >= 4) return 2'd2;
    else               return 2'd1;
  endfunction

  function automatic logic [WORD_W-1:0] dac_wr(input logic [CH_W-1:0] ch,
                                               input logic [HALF_W-1:0] smp);
    return {4'h0, DAC_OP_WRITE, 4'(ch), smp, 4'h0};
  endfunction

  function automatic logic [WORD_W-1:0] adc_cfg(input logic [CH_W-1:0] ch);
    return {16'h0, ADC_CFG_BASE | (16'(ch) << ADC_CH_LSB)};
  endfunction

  // result pipeline is two commands deep
  function automatic logic [CH_W-1:0] adc_sel(input logic [CH_W-1:0] ch,
                                              input logic [1:0] lg);
    logic [CH_W-1:0] m;
    m = CH_W'((4'd1 << lg) - 4'd1);
    return (ch + CH_W'(2)) & m;
  endfunction
endpackage

// File: rtl/spi_seq_xfer.sv
module spi_seq_xfer
  import spi_seq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  logic              go_adc,
  input  logic [WORD_W-1:0] go_word,
  output logic              dac_cs_n,
  output logic              adc_cs_n,
  output logic              xfer_req,
  output logic [WORD_W-1:0] xfer_word,
  output logic [5:0]        xfer_len,
  output logic [1:0]        xfer_mode,
  input  logic              xfer_done,
  input  logic [HALF_W-1:0] xfer_rx,
  output logic              fin,
  output logic [HALF_W-1:0] rx_q
);
  xfer_ph_t ph;
  logic     sel_adc;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph        <= XP_IDLE;
      sel_adc   <= 1'b0;
      xfer_word <= '0;
      fin       <= 1'b0;
      rx_q      <= '0;
    end else begin
      fin <= 1'b0;
      case (ph)
        XP_IDLE: if (go) begin
          ph        <= XP_SETUP;
          sel_adc   <= go_adc;
          xfer_word <= go_word;
        end
        XP_SETUP: ph <= XP_SHIFT;
        XP_SHIFT: if (xfer_done) begin
          ph   <= XP_IDLE;
          fin  <= 1'b1;
          rx_q <= xfer_rx;
        end
        default: ph <= XP_IDLE;
      endcase
    end
  end

  wire active = (ph != XP_IDLE);
  assign dac_cs_n  = !(active && !sel_adc);
  assign adc_cs_n  = !(active && sel_adc);
  assign xfer_req  = (ph == XP_SHIFT);
  assign xfer_len  = sel_adc ? 6'd16 : 6'd32;
  assign xfer_mode = sel_adc ? 2'd0 : 2'd1;

  // R8
  cs_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(!dac_cs_n && !adc_cs_n));
  // R9
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_req && !xfer_done) |=> xfer_req);
  // R8
  cs_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_req && xfer_done) |=> (dac_cs_n && adc_cs_n));
endmodule

// File: rtl/spi_seq_ctrl.sv
module spi_seq_ctrl
  import spi_seq_pkg::*;
#(
  parameter int REQ_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [REQ_W-1:0]  chan_req,
  input  logic              fin,
  input  logic [HALF_W-1:0] smp_lo,
  input  logic [HALF_W-1:0] smp_hi,
  output logic              go,
  output logic              go_adc,
  output logic [WORD_W-1:0] go_word,
  output logic              smp_take,
  output logic              ev_adc,
  output logic              ev_hi,
  output logic              ev_end
);
  seq_st_t           st;
  logic [STEP_W-1:0] step;
  logic              pend;
  logic [1:0]        nlog;
  logic [STEP_W:0]   span;
  logic [STEP_W-1:0] last_idx;
  logic              is_last;
  logic [CH_W-1:0]   ch;
  logic [HALF_W-1:0] half;

  wire in_fr   = (st == SQ_FRAME);
  wire in_init = (st == SQ_INIT);

  assign span     = (STEP_W+1)'(2) << nlog;
  assign last_idx = STEP_W'(span - 1'b1);
  assign is_last  = in_init ? (step == STEP_W'(INIT_LAST)) : (step == last_idx);
  assign ch       = step[STEP_W-1:1];
  assign half     = step[1] ? smp_hi : smp_lo;

  assign go       = (in_fr || in_init) && !pend;
  assign smp_take = go && in_fr && (step[1:0] == 2'b00);
  assign ev_adc   = fin && in_fr && step[0];
  assign ev_hi    = step[1];
  assign ev_end   = fin && in_fr && is_last;

  always_comb begin
    go_adc  = 1'b0;
    go_word = '0;
    if (in_init) begin
      case (step)
        STEP_W'(0): go_word = {8'h07, 24'h0};
        STEP_W'(1): begin go_adc = 1'b1; go_word = adc_cfg(CH_W'(0)); end
        STEP_W'(2): go_word = {8'h08, 23'h0, 1'b1};
        STEP_W'(3): begin go_adc = 1'b1; go_word = adc_cfg(CH_W'(0)); end
        default:    begin go_adc = 1'b1; go_word = adc_cfg(CH_W'(1)); end
      endcase
    end else if (step[0]) begin
      go_adc  = 1'b1;
      go_word = adc_cfg(adc_sel(ch, nlog));
    end else begin
      go_word = dac_wr(ch, half);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st   <= SQ_INIT;
      step <= '0;
      pend <= 1'b0;
      nlog <= 2'd1;
    end else begin
      if (go) pend <= 1'b1;
      if (fin) begin
        pend <= 1'b0;
        if (is_last) begin
          st   <= SQ_IDLE;
          step <= '0;
        end else begin
          step <= step + 1'b1;
        end
      end
      if (st == SQ_IDLE && start) begin
        st   <= SQ_FRAME;
        step <= '0;
        nlog <= norm_lg(32'(chan_req));
      end
    end
  end

  // R10
  nlog_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st != SQ_IDLE) |=> $stable(nlog));
  // R9
  fin_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fin |-> pend);
  // R7
  step_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_fr |-> (step <= last_idx));
endmodule

// File: rtl/spi_seq_pack.sv
module spi_seq_pack
  import spi_seq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              smp_take,
  input  logic [WORD_W-1:0] smp_word,
  input  logic              ev_adc,
  input  logic              ev_hi,
  input  logic              ev_end,
  input  logic [HALF_W-1:0] rx_q,
  output logic [HALF_W-1:0] smp_hi,
  output logic              res_valid,
  output logic [WORD_W-1:0] res_word,
  output logic              frame_done
);
  logic [HALF_W-1:0] lo_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      smp_hi     <= '0;
      lo_q       <= '0;
      res_valid  <= 1'b0;
      res_word   <= '0;
      frame_done <= 1'b0;
    end else begin
      res_valid  <= 1'b0;
      frame_done <= ev_end;
      if (smp_take) smp_hi <= smp_word[WORD_W-1:HALF_W];
      if (ev_adc && !ev_hi) lo_q <= rx_q;
      if (ev_adc && ev_hi) begin
        res_word  <= {rx_q, lo_q};
        res_valid <= 1'b1;
      end
    end
  end

  // R10
  done_with_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |-> res_valid);
endmodule

// File: rtl/spi_chan_seq.sv
module spi_chan_seq
  import spi_seq_pkg::*;
#(
  parameter int REQ_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [REQ_W-1:0]  chan_req,
  output logic              smp_req,
  input  logic [31:0]       smp_word,
  output logic              res_valid,
  output logic [31:0]       res_word,
  output logic              frame_done,
  output logic              dac_cs_n,
  output logic              adc_cs_n,
  output logic              xfer_req,
  output logic [31:0]       xfer_word,
  output logic [5:0]        xfer_len,
  output logic [1:0]        xfer_mode,
  input  logic              xfer_done,
  input  logic [15:0]       xfer_rx
);
  logic              go, go_adc, fin, ev_adc, ev_hi, ev_end;
  logic [WORD_W-1:0] go_word;
  logic [HALF_W-1:0] rx_q, smp_hi;

  spi_seq_ctrl #(.REQ_W(REQ_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .chan_req(chan_req), .fin(fin),
    .smp_lo(smp_word[HALF_W-1:0]), .smp_hi(smp_hi),
    .go(go), .go_adc(go_adc), .go_word(go_word), .smp_take(smp_req),
    .ev_adc(ev_adc), .ev_hi(ev_hi), .ev_end(ev_end)
  );

  spi_seq_xfer u_xfer (
    .clk(clk), .rst_n(rst_n), .go(go), .go_adc(go_adc), .go_word(go_word),
    .dac_cs_n(dac_cs_n), .adc_cs_n(adc_cs_n), .xfer_req(xfer_req),
    .xfer_word(xfer_word), .xfer_len(xfer_len), .xfer_mode(xfer_mode),
    .xfer_done(xfer_done), .xfer_rx(xfer_rx), .fin(fin), .rx_q(rx_q)
  );

  spi_seq_pack u_pack (
    .clk(clk), .rst_n(rst_n), .smp_take(smp_req), .smp_word(smp_word),
    .ev_adc(ev_adc), .ev_hi(ev_hi), .ev_end(ev_end), .rx_q(rx_q),
    .smp_hi(smp_hi), .res_valid(res_valid), .res_word(res_word),
    .frame_done(frame_done)
  );

  // R9
  go_idle_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
    go |-> (dac_cs_n && adc_cs_n));
endmodule

// File: tb/test_spi_chan_seq.sv
module test_spi_chan_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [7:0]  chan_req = 8'd0;
  logic        smp_req;
  logic [31:0] smp_word = 32'd0;
  logic        res_valid;
  logic [31:0] res_word;
  logic        frame_done;
  logic        dac_cs_n, adc_cs_n, xfer_req;
  logic [31:0] xfer_word;
  logic [5:0]  xfer_len;
  logic [1:0]  xfer_mode;
  logic        xfer_done = 1'b0;
  logic [15:0] xfer_rx = 16'd0;

  always #2.5 clk = ~clk;

  spi_chan_seq i_spi_chan_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .chan_req(chan_req),
    .smp_req(smp_req), .smp_word(smp_word), .res_valid(res_valid),
    .res_word(res_word), .frame_done(frame_done), .dac_cs_n(dac_cs_n),
    .adc_cs_n(adc_cs_n), .xfer_req(xfer_req), .xfer_word(xfer_word),
    .xfer_len(xfer_len), .xfer_mode(xfer_mode), .xfer_done(xfer_done),
    .xfer_rx(xfer_rx)
  );

  int nvec = 0;
  int nerr = 0;
  bit finished = 0;

  logic [31:0] exp_w [0:31];
  bit          exp_adc [0:31];
  int          exp_n = 0, eidx = 0;
  logic [15:0] frx [0:15];
  int          fidx = 0, rcnt = 0, fdcnt = 0, pidx = 0, phase = 0;
  logic [31:0] samples [0:3];
  logic [2:0]  h_new = 3'd0, h_old = 3'd0;
  logic [7:0]  aseq = 8'd0;
  bit          active = 0, smp_prev = 0;
  int          wait_n = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] expv);
    nvec++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  function automatic int bench_n(input int req);
    if (req >= 8) return 8;
    if (req >= 4) return 4;
    return 2;
  endfunction

  // serial engine model plus result monitor
  initial begin
    forever begin
      @(negedge clk);
      if (!rst_n) continue;
      if (smp_prev && pidx < 3) pidx++;
      smp_prev = smp_req;
      smp_word = samples[pidx];
      if (xfer_done) begin
        xfer_done = 1'b0;
        active = 0;
      end else if (xfer_req) begin
        if (!active) begin
          active = 1;
          wait_n = int'($urandom % 4);
        end
        if (wait_n == 0) begin
          if (eidx >= exp_n) begin
            chk(0, "R7 extra transfer", xfer_word, 32'd0);
          end else begin
            // R2 R3 R4 word contents
            chk(xfer_word == exp_w[eidx], "R2/R3/R4 word", xfer_word, exp_w[eidx]);
            // R8 framing
            chk(dac_cs_n == exp_adc[eidx] && adc_cs_n == !exp_adc[eidx],
                "R8 chip select", {dac_cs_n, adc_cs_n}, {exp_adc[eidx], !exp_adc[eidx]});
            chk(xfer_len == (exp_adc[eidx] ? 6'd16 : 6'd32) &&
                xfer_mode == (exp_adc[eidx] ? 2'd0 : 2'd1),
                "R8 len/mode", {xfer_len, xfer_mode}, exp_adc[eidx] ? {6'd16, 2'd0} : {6'd32, 2'd1});
            if (exp_adc[eidx]) begin
              xfer_rx = {4'h5, 1'b0, h_old, aseq};
              aseq++;
              h_old = h_new;
              h_new = xfer_word[11:9];
              if (phase == 1 && fidx < 16) begin
                frx[fidx] = xfer_rx;
                fidx++;
              end
            end else begin
              xfer_rx = 16'hDEAD;
            end
          end
          eidx++;
          xfer_done = 1'b1;
        end else begin
          wait_n--;
        end
      end
      if (res_valid) begin
        // R6 packing and channel alignment
        chk(res_word == {frx[2*rcnt+1], frx[2*rcnt]}, "R6 packing",
            res_word, {frx[2*rcnt+1], frx[2*rcnt]});
        chk(res_word[10:8] == 3'(2*rcnt) && res_word[26:24] == 3'(2*rcnt+1),
            "R6 channel alignment", res_word, 32'(rcnt));
        rcnt++;
      end
      if (frame_done) fdcnt++;
    end
  end

  task automatic run_frame(input int req, input bit poke);
    int n;
    n = bench_n(req);
    for (int p = 0; p < 4; p++) samples[p] = $urandom;
    for (int c = 0; c < n; c++) begin
      logic [15:0] h;
      h = (c % 2 == 1) ? samples[c/2][31:16] : samples[c/2][15:0];
      exp_w[2*c]   = 32'h0300_0000 | (32'(c) << 20) | (32'(h) << 4);
      exp_adc[2*c] = 0;
      exp_w[2*c+1] = 32'h0000_F120 | (32'((c + 2) % n) << 9);
      exp_adc[2*c+1] = 1;
    end
    exp_n = 2*n; eidx = 0; fidx = 0; rcnt = 0; fdcnt = 0; pidx = 0; phase = 1;
    smp_word = samples[0];
    @(negedge clk);
    chan_req = 8'(req);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (poke) begin
      repeat (12) @(negedge clk);
      chan_req = 8'd8;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    for (int t = 0; t < 5000 && fdcnt == 0; t++) @(negedge clk);
    repeat (6) @(negedge clk);
    chk(eidx == exp_n, "R7 transfer count", 32'(eidx), 32'(exp_n));
    chk(rcnt == n/2, "R5/R6 result count", 32'(rcnt), 32'(n/2));
    chk(fdcnt == 1, "R10 frame_done once", 32'(fdcnt), 32'd1);
  endtask

  task automatic summary;
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nvec++; nerr++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
    summary();
  end

  initial begin
    void'($urandom(32'd1234));
    for (int p = 0; p < 4; p++) samples[p] = 32'd0;
    exp_w[0] = 32'h0700_0000; exp_adc[0] = 0;
    exp_w[1] = 32'h0000_F120; exp_adc[1] = 1;
    exp_w[2] = 32'h0800_0001; exp_adc[2] = 0;
    exp_w[3] = 32'h0000_F120; exp_adc[3] = 1;
    exp_w[4] = 32'h0000_F320; exp_adc[4] = 1;
    exp_n = 5;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk(dac_cs_n && adc_cs_n && !xfer_req && !smp_req && !res_valid && !frame_done,
        "R1 reset state", {dac_cs_n, adc_cs_n, xfer_req, smp_req, res_valid, frame_done},
        32'b110000);
    rst_n = 1'b1;
    @(negedge clk);
    chan_req = 8'd8;
    start = 1'b1;      // R10: ignored during power-up
    @(negedge clk);
    start = 1'b0;
    for (int t = 0; t < 2000 && eidx < 5; t++) @(negedge clk);
    repeat (30) @(negedge clk);
    chk(eidx == 5, "R2/R10 power-up only", 32'(eidx), 32'd5);
    chk(!xfer_req && dac_cs_n && adc_cs_n && fdcnt == 0, "R2 idle after power-up",
        {xfer_req, dac_cs_n, adc_cs_n}, 32'b011);
    // directed channel counts (R7 rounding)
    run_frame(8, 0);
    run_frame(4, 0);
    run_frame(2, 0);
    run_frame(3, 0);
    run_frame(7, 0);
    run_frame(0, 0);
    run_frame(100, 0);
    run_frame(2, 1);   // R10: start mid-frame ignored
    run_frame(5, 1);
    for (int k = 0; k < 20; k++) run_frame(int'($urandom % 12), k % 5 == 0);
    summary();
  end
endmodule